// File: doc/BRIEF.md
# Character LCD 4-bit Bus Interface

This block connects client logic to a character LCD controller through a 4-bit parallel bus with a register-select line (RS), a read/write line (RW) and an enable strobe (E). The client hands over one byte at a time, tagged as either an instruction or display data. The block first reads the controller's status byte and repeats that read until the busy bit clears. It then writes the client's byte as two nibbles. All strobe widths and setup times are counted in system clock cycles. Each count is derived from the clock frequency parameter and rounded up.

The data pins are split into an output value, an output enable and an input value, so that a pad ring can build the bidirectional pin. Direction changes are ordered so that the block and the LCD never both drive the pins. Every status read is also reported to the client on plain status pins: the busy bit and the 7-bit address counter, with a one-cycle strobe.

The request side is valid/ready. A byte is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low until that byte has been fully written to the LCD. While `req_ready` is low, the block does not look at `req_valid`, `req_is_data` or `req_byte`. The client may hold or change them during that time, and no extra byte is taken. The client holds `req_valid` until a handshake occurs.

Top module: `lcd_nibble_bus`

## Requirements
- R1: After reset, `req_ready`=1, `lcd_e`=0, `lcd_rw`=0, `lcd_db_oe`=1 and `stat_valid`=0.
- R2: A byte is accepted only in a cycle with `req_valid`=1 and `req_ready`=1. `req_ready` is 0 from the next cycle until the E low phase that follows the second written nibble has ended. Request inputs seen while `req_ready`=0 take no byte.
- R3: Before each byte is written, the status is read with RS=0 and RW=1 using two E pulses, high nibble first. The read is repeated while bit 7 (busy) of the status byte is 1, and the write starts only after a read with busy=0.
- R4: A byte is written with RW=0 using two E pulses. The high nibble (bits 7..4) comes first, each nibble is taken on the falling edge of E, and RS is 1 for data and 0 for instructions. RS is set again for every data byte, after its status read.
- R5: `lcd_db_oe` and `lcd_rw` are never 1 in the same cycle. The pins are released before RW rises, and RW is low before the pins are driven again.
- R6: Every E high pulse lasts at least ceil(450 ns / Tclk) cycles, which also covers the 360 ns needed before read data is sampled. The time from one rising edge of E to the next is at least ceil(500 ns / Tclk) cycles.
- R7: During a write pulse, `lcd_db_out` is driven and holds one value for the whole time E is high. That time is at least ceil(195 ns / Tclk) cycles of setup before the falling edge.
- R8: After each completed status read, `stat_valid` pulses for one cycle. In that cycle `stat_busy` equals status bit 7 and `stat_addr` equals status bits 6..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client offers a byte |
| req_ready | output | 1 | Block can take a byte |
| req_is_data | input | 1 | 1: display data, 0: instruction |
| req_byte | input | 8 | Byte to write |
| lcd_rs | output | 1 | Register select to LCD |
| lcd_rw | output | 1 | 1 read, 0 write |
| lcd_e | output | 1 | Enable strobe |
| lcd_db_out | output | 4 | Nibble driven onto DB7..DB4 |
| lcd_db_oe | output | 1 | Drive enable for the data pins |
| lcd_db_in | input | 4 | Value read from DB7..DB4 |
| stat_valid | output | 1 | One-cycle strobe per status read |
| stat_busy | output | 1 | Busy bit of the last status read |
| stat_addr | output | 7 | Address counter of the last status read |

## Verification
A behavioural LCD model answers the status reads and logs every written nibble pair. A single instruction tests the RS=0 path and gives a baseline of exactly one status read. A run of data bytes checks that RS is set again after each poll and that the reported address counter follows the model's counter. A controller that stays busy for two reads shows that the poll repeats and that the write waits; a wrong nibble order is caught here as a misread busy bit. Holding `req_valid` high while changing the byte during a transfer separates correct back-pressure from a second, unwanted acceptance.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD_REL,
    PH_RD_SETUP,
    PH_RD_EHI,
    PH_RD_ELO,
    PH_WR_SETUP,
    PH_WR_EHI,
    PH_WR_ELO
  } phase_t;

  // Convert a time in ns to whole clock cycles, rounded up.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned hz);
    longint unsigned prod;
    prod = 64'(ns) * 64'(hz);
    return 32'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  // A phase loaded with len lasts exactly len cycles: the entry cycle holds len-1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= len - CW'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign expired = (cnt_q == '0);

  // R6: a zero-length phase would collapse a strobe
  a_r6_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (len != '0));

endmodule

// File: rtl/lcd_status_capture.sv
module lcd_status_capture (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample,
  input  logic       sample_low,
  input  logic [3:0] db_in,
  output logic       busy,
  output logic [6:0] addr,
  output logic       valid
);

  logic [3:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      busy  <= 1'b0;
      addr  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (sample && !sample_low) begin
        hi_q <= db_in;
      end
      if (sample && sample_low) begin
        busy  <= hi_q[3];
        addr  <= {hi_q[2:0], db_in};
        valid <= 1'b1;
      end
    end
  end

  // R8: the report strobe is a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R3: the low nibble is never sampled twice in consecutive cycles
  a_r3_no_back_to_back_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && sample_low) |=> !(sample && sample_low));

endmodule

// File: rtl/lcd_nibble_bus.sv
module lcd_nibble_bus #(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned T_EH_NS  = 450,
  parameter int unsigned T_DSW_NS = 195,
  parameter int unsigned T_DDR_NS = 360,
  parameter int unsigned T_CYC_NS = 500,
  parameter int unsigned T_AS_NS  = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_is_data,
  input  logic [7:0] req_byte,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [3:0] lcd_db_out,
  output logic       lcd_db_oe,
  input  logic [3:0] lcd_db_in,
  output logic       stat_valid,
  output logic       stat_busy,
  output logic [6:0] stat_addr
);

  import lcd_bus_pkg::*;

  localparam int unsigned EH_C  = at_least_one(ns_to_cycles(T_EH_NS,  CLK_HZ));
  localparam int unsigned DSW_C = at_least_one(ns_to_cycles(T_DSW_NS, CLK_HZ));
  localparam int unsigned DDR_C = at_least_one(ns_to_cycles(T_DDR_NS, CLK_HZ));
  localparam int unsigned CYC_C = at_least_one(ns_to_cycles(T_CYC_NS, CLK_HZ));
  localparam int unsigned AS_C  = at_least_one(ns_to_cycles(T_AS_NS,  CLK_HZ));
  localparam int unsigned RD_HI = max2(EH_C, DDR_C);
  localparam int unsigned WR_HI = max2(EH_C, DSW_C);
  localparam int unsigned RD_LO = (CYC_C > RD_HI) ? (CYC_C - RD_HI) : 1;
  localparam int unsigned WR_LO = (CYC_C > WR_HI) ? (CYC_C - WR_HI) : 1;
  localparam int unsigned LEN_MAX = max2(max2(RD_HI, WR_HI), max2(max2(RD_LO, WR_LO), AS_C));
  localparam int unsigned CW = $clog2(LEN_MAX + 1);

  phase_t        ph_q, ph_d;
  logic          nib_q, nib_d;
  logic          is_data_q;
  logic [7:0]    byte_q;
  logic          accept;
  logic          t_load;
  logic [CW-1:0] t_len;
  logic          t_expired;
  logic          sample;

  lcd_phase_timer #(.CW(CW)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (t_load),
    .len     (t_len),
    .expired (t_expired)
  );

  assign sample = (ph_q == PH_RD_EHI) && t_expired;

  lcd_status_capture capture_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample     (sample),
    .sample_low (nib_q),
    .db_in      (lcd_db_in),
    .busy       (stat_busy),
    .addr       (stat_addr),
    .valid      (stat_valid)
  );

  assign req_ready = (ph_q == PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    ph_d   = ph_q;
    nib_d  = nib_q;
    t_load = 1'b0;
    t_len  = CW'(1);
    case (ph_q)
      PH_IDLE: if (req_valid) begin
        ph_d = PH_RD_REL; t_load = 1'b1; t_len = CW'(1);
      end
      PH_RD_REL: if (t_expired) begin
        ph_d = PH_RD_SETUP; t_load = 1'b1; t_len = CW'(AS_C);
      end
      PH_RD_SETUP: if (t_expired) begin
        ph_d = PH_RD_EHI; nib_d = 1'b0; t_load = 1'b1; t_len = CW'(RD_HI);
      end
      PH_RD_EHI: if (t_expired) begin
        ph_d = PH_RD_ELO; t_load = 1'b1; t_len = CW'(RD_LO);
      end
      PH_RD_ELO: if (t_expired) begin
        t_load = 1'b1;
        if (!nib_q) begin
          ph_d = PH_RD_EHI; nib_d = 1'b1; t_len = CW'(RD_HI);
        end else if (stat_busy) begin
          ph_d = PH_RD_EHI; nib_d = 1'b0; t_len = CW'(RD_HI);
        end else begin
          ph_d = PH_WR_SETUP; t_len = CW'(AS_C);
        end
      end
      PH_WR_SETUP: if (t_expired) begin
        ph_d = PH_WR_EHI; nib_d = 1'b0; t_load = 1'b1; t_len = CW'(WR_HI);
      end
      PH_WR_EHI: if (t_expired) begin
        ph_d = PH_WR_ELO; t_load = 1'b1; t_len = CW'(WR_LO);
      end
      PH_WR_ELO: if (t_expired) begin
        if (!nib_q) begin
          ph_d = PH_WR_EHI; nib_d = 1'b1; t_load = 1'b1; t_len = CW'(WR_HI);
        end else begin
          ph_d = PH_IDLE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      nib_q     <= 1'b0;
      is_data_q <= 1'b0;
      byte_q    <= '0;
    end else begin
      ph_q  <= ph_d;
      nib_q <= nib_d;
      if (accept) begin
        is_data_q <= req_is_data;
        byte_q    <= req_byte;
      end
    end
  end

  assign lcd_e      = (ph_q == PH_RD_EHI) || (ph_q == PH_WR_EHI);
  assign lcd_rw     = ph_q inside {PH_RD_SETUP, PH_RD_EHI, PH_RD_ELO};
  assign lcd_db_oe  = !(ph_q inside {PH_RD_REL, PH_RD_SETUP, PH_RD_EHI, PH_RD_ELO, PH_WR_SETUP});
  assign lcd_rs     = (ph_q inside {PH_WR_SETUP, PH_WR_EHI, PH_WR_ELO}) ? is_data_q : 1'b0;
  assign lcd_db_out = nib_q ? byte_q[3:0] : byte_q[7:4];

  // Length of the current E high run, kept for the width check.
  logic [CW-1:0] e_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_run_q <= '0;
    end else if (lcd_e) begin
      e_run_q <= e_run_q + CW'(1);
    end else begin
      e_run_q <= '0;
    end
  end

  a_r2_ready_drops_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_db_oe |-> !lcd_rw);

  a_r4_ctrl_stable_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && $past(lcd_e)) |-> ($stable(lcd_rw) && $stable(lcd_rs)));

  a_r6_e_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> (e_run_q >= CW'(EH_C)));

  a_r7_write_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && !lcd_rw && $past(lcd_e)) |-> $stable(lcd_db_out));

endmodule

// File: tb/lcd_nibble_bus_tb_top.sv
module lcd_nibble_bus_tb_top;

  localparam int CLK_PERIOD_NS = 20;
  localparam int EH_MIN  = (450 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int CYC_MIN = (500 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_is_data = 1'b0;
  logic [7:0] req_byte = '0;
  logic       lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
  logic [3:0] lcd_db_out, lcd_db_in;
  logic       stat_valid, stat_busy;
  logic [6:0] stat_addr;

  always #(CLK_PERIOD_NS / 2) clk = ~clk;

  lcd_nibble_bus #(.CLK_HZ(1_000_000_000 / CLK_PERIOD_NS)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_is_data(req_is_data), .req_byte(req_byte),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
    .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in),
    .stat_valid(stat_valid), .stat_busy(stat_busy), .stat_addr(stat_addr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- LCD controller model ----------------
  logic [7:0] wr_log_byte [0:63];
  bit         wr_log_rs   [0:63];
  int         wr_n = 0;
  int         reads_n = 0;
  int         stat_n = 0;
  int         busy_left = 0;
  int         busy_cfg = 0;
  logic [6:0] lcd_addr = '0;
  bit         rd_nib = 1'b0;
  bit         wr_nib = 1'b0;
  logic [3:0] wr_hi = '0;
  bit         wr_rs0 = 1'b0;
  int         viol_r5 = 0, viol_r6 = 0, viol_r7 = 0, viol_rs = 0, viol_busy = 0;
  logic       e_prev = 1'b0;
  int         hi_cnt = 0, since_rise = 0;
  bit         seen_rise = 1'b0;
  logic [3:0] db_at_rise = '0;
  bit         last_busy = 1'b0;
  logic [6:0] last_addr = '0;
  logic [7:0] stat_byte;

  assign stat_byte = {busy_left > 0, lcd_addr};
  assign lcd_db_in = rd_nib ? stat_byte[3:0] : stat_byte[7:4];

  always @(negedge clk) begin
    if (rst_n) begin
      if (lcd_db_oe && lcd_rw) viol_r5++;
      since_rise++;
      if (lcd_e && !e_prev) begin
        if (seen_rise && since_rise < CYC_MIN) viol_r6++;
        seen_rise = 1'b1;
        since_rise = 0;
        hi_cnt = 0;
        db_at_rise = lcd_db_out;
      end
      if (lcd_e) begin
        hi_cnt++;
        if (!lcd_rw && (lcd_db_out !== db_at_rise || !lcd_db_oe)) viol_r7++;
      end
      if (!lcd_e && e_prev) begin
        if (hi_cnt < EH_MIN) viol_r6++;
        if (lcd_rw) begin
          if (lcd_rs) viol_rs++;
          if (rd_nib) begin
            reads_n++;
            if (busy_left > 0) busy_left--;
          end
          rd_nib = !rd_nib;
        end else begin
          if (!wr_nib) begin
            wr_hi = lcd_db_out;
            wr_rs0 = lcd_rs;
          end else begin
            if (lcd_rs != wr_rs0) viol_rs++;
            if (busy_left > 0) viol_busy++;
            if (wr_n < 64) begin
              wr_log_byte[wr_n] = {wr_hi, lcd_db_out};
              wr_log_rs[wr_n] = lcd_rs;
            end
            wr_n++;
            if (lcd_rs) lcd_addr = lcd_addr + 7'd1;
            busy_left = busy_cfg;
          end
          wr_nib = !wr_nib;
        end
      end
      e_prev = lcd_e;
      if (stat_valid) begin
        stat_n++;
        last_busy = stat_busy;
        last_addr = stat_addr;
      end
    end
  end

  // ---------------- scenario tasks ----------------
  task automatic send(input bit d, input logic [7:0] b);
    int w0;
    w0 = wr_n;
    @(negedge clk);
    req_valid = 1'b1; req_is_data = d; req_byte = b;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R2 ready low after accept", int'(req_ready), 0);
    while (!req_ready) @(negedge clk);
    check(wr_n == w0 + 1 && !wr_nib, "R2 ready back only after second nibble", wr_n - w0, 1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(lcd_e == 1'b0, "R1 E low after reset", int'(lcd_e), 0);
    check(lcd_rw == 1'b0, "R1 RW low after reset", int'(lcd_rw), 0);
    check(lcd_db_oe == 1'b1, "R1 bus driven after reset", int'(lcd_db_oe), 1);
    check(stat_valid == 1'b0, "R1 no status strobe after reset", int'(stat_valid), 0);
  endtask

  task automatic t_instruction;
    int r0, s0, w0;
    r0 = reads_n; s0 = stat_n; w0 = wr_n;
    busy_cfg = 0;
    send(1'b0, 8'h28);
    check(wr_log_byte[w0] == 8'h28, "R4 instruction byte high nibble first", int'(wr_log_byte[w0]), 'h28);
    check(wr_log_rs[w0] == 1'b0, "R4 RS low for instruction", int'(wr_log_rs[w0]), 0);
    check(reads_n - r0 == 1, "R3 one status read when idle", reads_n - r0, 1);
    check(stat_n - s0 == 1, "R8 one strobe per read", stat_n - s0, 1);
    check(last_busy == 1'b0 && last_addr == 7'd0, "R8 status content", int'({last_busy, last_addr}), 0);
  endtask

  task automatic t_data_run;
    logic [7:0] vals [0:2];
    int r0, w0;
    vals[0] = 8'h41; vals[1] = 8'hA5; vals[2] = 8'h3C;
    r0 = reads_n; w0 = wr_n;
    for (int i = 0; i < 3; i++) begin
      logic [6:0] a_exp;
      a_exp = lcd_addr;
      send(1'b1, vals[i]);
      check(wr_log_byte[w0 + i] == vals[i], "R4 data byte value", int'(wr_log_byte[w0 + i]), int'(vals[i]));
      check(wr_log_rs[w0 + i] == 1'b1, "R4 RS high for each data byte", int'(wr_log_rs[w0 + i]), 1);
      check(last_addr == a_exp, "R8 address counter reported", int'(last_addr), int'(a_exp));
    end
    check(reads_n - r0 == 3, "R3 a status read before every byte", reads_n - r0, 3);
  endtask

  task automatic t_busy_poll;
    int r0, s0, w0;
    busy_cfg = 2;
    send(1'b0, 8'h01);
    busy_cfg = 0;
    r0 = reads_n; s0 = stat_n; w0 = wr_n;
    send(1'b1, 8'h5A);
    check(reads_n - r0 == 3, "R3 poll repeats while busy", reads_n - r0, 3);
    check(stat_n - s0 == 3, "R8 strobe for every poll read", stat_n - s0, 3);
    check(last_busy == 1'b0, "R8 last poll reports not busy", int'(last_busy), 0);
    check(wr_log_byte[w0] == 8'h5A, "R3 byte written after busy clears", int'(wr_log_byte[w0]), 'h5A);
    check(viol_busy == 0, "R3 no write while busy", viol_busy, 0);
  endtask

  task automatic t_hold_valid;
    int w0;
    w0 = wr_n;
    @(negedge clk);
    req_valid = 1'b1; req_is_data = 1'b1; req_byte = 8'h33;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_byte = 8'hCC; req_is_data = 1'b0;
    repeat (60) @(negedge clk);
    check(req_ready == 1'b0, "R2 still busy while valid held", int'(req_ready), 0);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    repeat (150) @(negedge clk);
    check(wr_n - w0 == 1, "R2 held valid takes no second byte", wr_n - w0, 1);
    check(wr_log_byte[w0] == 8'h33 && wr_log_rs[w0], "R2 byte captured at handshake", int'(wr_log_byte[w0]), 'h33);
  endtask

  task automatic t_bus_rules;
    check(viol_r5 == 0, "R5 no drive while RW high", viol_r5, 0);
    check(viol_r6 == 0, "R6 E pulse and cycle widths", viol_r6, 0);
    check(viol_r7 == 0, "R7 write nibble stable while E high", viol_r7, 0);
    check(viol_rs == 0, "R4 RS consistent, low during reads", viol_rs, 0);
  endtask

  initial begin
    t_reset();
    t_instruction();
    t_data_run();
    t_busy_poll();
    t_hold_valid();
    t_bus_rules();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD_NS * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule